// File: doc/BRIEF.md
# Descriptor-Driven DMA Transfer Sequencer

This block moves a run of data items for a single DMA channel. A three-word descriptor is loaded in one cycle. The first word is the inclusive last source address. The second is the inclusive last destination address. The third is a control word. From the descriptor the engine works out each source-read and destination-write address. It counts backwards from the end pointers, so item k of an N-item run sits at `end - (N-1-k)*step`. A step code of "no increment" pins every access to the end pointer, as for a peripheral data register.

Work is split into bursts. Before each burst the engine asks an external arbiter for the bus and waits for a grant. It then moves up to 2^a items, where a is the arbitration field. When a burst ends early, the engine writes the control word back with the count field holding the items still outstanding minus one. It then pauses. In basic mode, each pause waits for the channel request to be present again. In auto mode, the run goes on to the end once it has started. At completion the control word is written back with mode stop and a count of zero, and `done` pulses for one clock. A descriptor whose sizes or steps are illegal raises a one-cycle configuration error and moves nothing.

Top module: `dma_desc_engine`

## Requirements
- R1: After reset, `arb_req`, `mem_rd`, `mem_wr`, `desc_wr`, `done`, `cfg_err` and `busy` are all low.
- R2: A descriptor whose mode field (control bits 2:0) is 0 (stop) is accepted without effect: no request, no memory access, no `done`, no `cfg_err`.
- R3: A descriptor is rejected with a one-clock `cfg_err` pulse, one cycle after the load, and no transfer in any of these cases: a size code of 3 on either side (size: bits 25:24 source, 29:28 destination; 0 = 8-bit, 1 = 16-bit, 2 = 32-bit), source and destination sizes that differ, a step code below the size code on a side whose step is not 3, or a mode above 2.
- R4: Item k (0-based) of N is read at `src_end - (N-1-k)*s` and written at `dst_end - (N-1-k)*d`. Here s and d are 1, 2 or 4 bytes for step codes 0, 1 and 2, and 0 for step code 3. The step codes sit in bits 27:26 (source) and 31:30 (destination).
- R5: N equals the count field (bits 13:4) plus one, and ranges from 1 to 1024. Each read is followed in the next cycle by its write. The write carries the data returned for that read.
- R6: Each grant is followed by at most B items, where B = 2^a for an arbitration field a (bits 17:14) of 0 to 9, and B = 1024 for 10 to 15. A run uses ceil(N/B) grants.
- R7: When a burst ends with items outstanding, one `desc_wr` presents the loaded control word with bits 13:4 replaced by the outstanding count minus one and every other bit unchanged.
- R8: After the last item, one `desc_wr` presents the control word with bits 13:4 and 2:0 cleared. `done` is high in that same cycle only.
- R9: In basic mode (mode 1), a pause holds `arb_req` and the memory strobes low while `chan_req` is low. The run resumes when `chan_req` returns.
- R10: In auto mode (mode 2), the run completes even if `chan_req` falls after the first grant.
- R11: `mem_size` equals the source size code, `mem_rd_priv` equals control bit 18, and `mem_wr_priv` equals control bit 21, during every access.
- R12: A descriptor load while `busy` is high is ignored and does not change the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_valid | input | 1 | Descriptor load strobe, taken only when idle |
| load_src_end | input | 32 | Inclusive last source address |
| load_dst_end | input | 32 | Inclusive last destination address |
| load_ctrl | input | 32 | Control word |
| chan_req | input | 1 | Channel request (start / resume) |
| arb_req | output | 1 | Bus request to the arbiter |
| arb_gnt | input | 1 | Grant from the arbiter |
| mem_rd | output | 1 | Read strobe |
| mem_rd_addr | output | 32 | Read address |
| mem_rd_data | input | 32 | Read data, valid and held from the cycle after `mem_rd` |
| mem_wr | output | 1 | Write strobe |
| mem_wr_addr | output | 32 | Write address |
| mem_wr_data | output | 32 | Write data |
| mem_size | output | 2 | Item size code |
| mem_rd_priv | output | 1 | Privileged source read |
| mem_wr_priv | output | 1 | Privileged destination write |
| desc_wr | output | 1 | Control word write-back strobe |
| desc_ctrl | output | 32 | Control word being written back |
| done | output | 1 | One-clock completion pulse |
| cfg_err | output | 1 | One-clock configuration error pulse |
| busy | output | 1 | A descriptor is active |

## Verification
The hardest situation to reach is a basic-mode pause in which the channel request is absent. The request has to fall in the exact cycle of an intermediate write-back, and stay low long enough to show that nothing moves. The bench drops `chan_req` from its monitor in the cycle it sees `desc_wr`. It holds the request low for 20 cycles and counts any request or memory strobe in that window. It also drops the request for good after the first grant of an auto-mode run. A load is injected in the middle of a run to show it is ignored. Random descriptors with short counts and small arbitration sizes produce many bursts per run. Directed runs of 1024 items cover the no-re-arbitration and two-burst cases.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

    // Control word field positions (the write-back format depends on them)
    localparam int DINC_LO   = 30;
    localparam int DSZ_LO    = 28;
    localparam int SINC_LO   = 26;
    localparam int SSZ_LO    = 24;
    localparam int DPRIV_BIT = 21;
    localparam int SPRIV_BIT = 18;
    localparam int ARB_LO    = 14;
    localparam int ARB_W     = 4;
    localparam int CNT_LO    = 4;
    localparam int MODE_LO   = 0;
    localparam int MODE_W    = 3;

    localparam logic [MODE_W-1:0] MODE_STOP  = 3'd0;
    localparam logic [MODE_W-1:0] MODE_BASIC = 3'd1;
    localparam logic [MODE_W-1:0] MODE_AUTO  = 3'd2;

    localparam logic [1:0] STEP_NONE = 2'd3;
    localparam logic [1:0] SIZE_RSVD = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PEND,
        ST_ARB,
        ST_RD,
        ST_WR,
        ST_WB,
        ST_FIN
    } eng_st_e;

endpackage

// File: rtl/dma_cfg_check.sv
module dma_cfg_check
    import dma_desc_pkg::*;
(
    input  logic [1:0]        src_step,
    input  logic [1:0]        dst_step,
    input  logic [1:0]        src_size,
    input  logic [1:0]        dst_size,
    input  logic [MODE_W-1:0] mode,
    output logic              is_stop,
    output logic              is_bad
);
    logic size_bad;
    logic step_bad;
    logic mode_bad;

    always_comb begin
        size_bad = (src_size == SIZE_RSVD) || (dst_size == SIZE_RSVD)
                || (src_size != dst_size);
        step_bad = ((src_step != STEP_NONE) && (src_step < src_size))
                || ((dst_step != STEP_NONE) && (dst_step < dst_size));
        mode_bad = (mode > MODE_AUTO);
        is_stop  = (mode == MODE_STOP);
        is_bad   = !is_stop && (size_bad || step_bad || mode_bad);
    end
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_desc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REM_W  = 11
) (
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [1:0]        step,
    input  logic [REM_W-1:0]  remaining,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] items_back;
    logic [ADDR_W-1:0] byte_back;

    always_comb begin
        // items still ahead of this one, excluding itself
        items_back = ADDR_W'(remaining - REM_W'(1));
        byte_back  = items_back << step;
        if (step == STEP_NONE) begin
            addr = end_addr;
        end else begin
            addr = end_addr - byte_back;
        end
    end
endmodule

// File: rtl/dma_desc_engine.sv
module dma_desc_engine
    import dma_desc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_valid,
    input  logic [ADDR_W-1:0] load_src_end,
    input  logic [ADDR_W-1:0] load_dst_end,
    input  logic [31:0]       load_ctrl,
    input  logic              chan_req,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic [1:0]        mem_size,
    output logic              mem_rd_priv,
    output logic              mem_wr_priv,
    output logic              desc_wr,
    output logic [31:0]       desc_ctrl,
    output logic              done,
    output logic              cfg_err,
    output logic              busy
);
    localparam int REM_W  = CNT_W + 1;
    localparam int N_SIDE = 2;

    typedef struct packed {
        eng_st_e           st;
        logic [ADDR_W-1:0] src_end;
        logic [ADDR_W-1:0] dst_end;
        logic [31:0]       ctrl;
        logic [REM_W-1:0]  rem;
        logic [REM_W-1:0]  left;
        logic              err;
    } eng_t;

    eng_t eng_d, eng_q;

    function automatic logic [REM_W-1:0] burst_of(input logic [ARB_W-1:0] a);
        if (a >= ARB_W'(CNT_W)) begin
            return REM_W'(1) << CNT_W;
        end
        return REM_W'(1) << a;
    endfunction

    // load-time configuration screen
    logic ld_stop, ld_bad;

    dma_cfg_check u_cfg (
        .src_step (load_ctrl[SINC_LO +: 2]),
        .dst_step (load_ctrl[DINC_LO +: 2]),
        .src_size (load_ctrl[SSZ_LO +: 2]),
        .dst_size (load_ctrl[DSZ_LO +: 2]),
        .mode     (load_ctrl[MODE_LO +: MODE_W]),
        .is_stop  (ld_stop),
        .is_bad   (ld_bad)
    );

    // address generators, one per side (0 = source, 1 = destination)
    logic [ADDR_W-1:0] side_end  [N_SIDE];
    logic [1:0]        side_step [N_SIDE];
    logic [ADDR_W-1:0] side_addr [N_SIDE];

    always_comb begin
        side_end[0]  = eng_q.src_end;
        side_end[1]  = eng_q.dst_end;
        side_step[0] = eng_q.ctrl[SINC_LO +: 2];
        side_step[1] = eng_q.ctrl[DINC_LO +: 2];
    end

    for (genvar g = 0; g < N_SIDE; g++) begin : g_side
        dma_addr_gen #(
            .ADDR_W (ADDR_W),
            .REM_W  (REM_W)
        ) u_addr (
            .end_addr  (side_end[g]),
            .step      (side_step[g]),
            .remaining (eng_q.rem),
            .addr      (side_addr[g])
        );
    end

    // next-state logic
    always_comb begin
        eng_d     = eng_q;
        eng_d.err = 1'b0;
        case (eng_q.st)
            ST_IDLE: begin
                if (load_valid) begin
                    eng_d.src_end = load_src_end;
                    eng_d.dst_end = load_dst_end;
                    eng_d.ctrl    = load_ctrl;
                    eng_d.rem     = REM_W'(load_ctrl[CNT_LO +: CNT_W]) + REM_W'(1);
                    if (ld_bad) begin
                        eng_d.err = 1'b1;
                    end else if (!ld_stop) begin
                        eng_d.st = ST_PEND;
                    end
                end
            end
            ST_PEND: begin
                if (chan_req) begin
                    eng_d.st = ST_ARB;
                end
            end
            ST_ARB: begin
                if (arb_gnt) begin
                    eng_d.left = burst_of(eng_q.ctrl[ARB_LO +: ARB_W]);
                    eng_d.st   = ST_RD;
                end
            end
            ST_RD: begin
                eng_d.st = ST_WR;
            end
            ST_WR: begin
                eng_d.rem  = eng_q.rem - REM_W'(1);
                eng_d.left = eng_q.left - REM_W'(1);
                if (eng_q.rem == REM_W'(1)) begin
                    eng_d.ctrl[CNT_LO +: CNT_W]   = '0;
                    eng_d.ctrl[MODE_LO +: MODE_W] = MODE_STOP;
                    eng_d.st = ST_FIN;
                end else if (eng_q.left == REM_W'(1)) begin
                    eng_d.ctrl[CNT_LO +: CNT_W] = CNT_W'(eng_q.rem - REM_W'(2));
                    eng_d.st = ST_WB;
                end else begin
                    eng_d.st = ST_RD;
                end
            end
            ST_WB: begin
                if (eng_q.ctrl[MODE_LO +: MODE_W] == MODE_AUTO) begin
                    eng_d.st = ST_ARB;
                end else begin
                    eng_d.st = ST_PEND;
                end
            end
            ST_FIN: begin
                eng_d.st = ST_IDLE;
            end
            default: begin
                eng_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: ST_IDLE, default: '0};
        end else begin
            eng_q <= eng_d;
        end
    end

    // outputs
    always_comb begin
        arb_req     = (eng_q.st == ST_ARB);
        mem_rd      = (eng_q.st == ST_RD);
        mem_wr      = (eng_q.st == ST_WR);
        mem_rd_addr = side_addr[0];
        mem_wr_addr = side_addr[1];
        mem_wr_data = mem_rd_data;
        mem_size    = eng_q.ctrl[SSZ_LO +: 2];
        mem_rd_priv = eng_q.ctrl[SPRIV_BIT];
        mem_wr_priv = eng_q.ctrl[DPRIV_BIT];
        desc_wr     = (eng_q.st == ST_WB) || (eng_q.st == ST_FIN);
        desc_ctrl   = eng_q.ctrl;
        done        = (eng_q.st == ST_FIN);
        cfg_err     = eng_q.err;
        busy        = (eng_q.st != ST_IDLE);
    end
endmodule

// File: rtl/dma_desc_checker.sv
module dma_desc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        arb_req,
    input logic        arb_gnt,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        desc_wr,
    input logic [31:0] desc_ctrl,
    input logic        done,
    input logic        cfg_err,
    input logic        busy
);
    a_r5_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    a_r5_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    a_r6_read_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !$past(mem_wr)) |-> $past(arb_gnt));

    a_r7_writeback_after_item: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr |-> $past(mem_wr));

    a_r8_done_writes_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (desc_wr && (desc_ctrl[2:0] == 3'd0) && (desc_ctrl[13:4] == 10'd0)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r3_error_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!busy && !arb_req && !mem_rd));

    a_r3_error_single: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> !cfg_err);
endmodule

bind dma_desc_engine dma_desc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arb_req   (arb_req),
    .arb_gnt   (arb_gnt),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .desc_wr   (desc_wr),
    .desc_ctrl (desc_ctrl),
    .done      (done),
    .cfg_err   (cfg_err),
    .busy      (busy)
);

// File: tb/sim_dma_desc_engine.sv
module sim_dma_desc_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_valid = 1'b0;
    logic [31:0] load_src_end = '0, load_dst_end = '0, load_ctrl = '0;
    logic        chan_req = 1'b0;
    logic        arb_req, arb_gnt = 1'b0;
    logic        mem_rd, mem_wr, mem_rd_priv, mem_wr_priv;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic [31:0] mem_rd_data = '0;
    logic [1:0]  mem_size;
    logic        desc_wr, done, cfg_err, busy;
    logic [31:0] desc_ctrl;

    dma_desc_engine u0 (.*);

    always #10 clk = ~clk;   // 50 MHz

    int n_chk = 0, n_fail = 0, cycles = 0;

    // logs filled by the monitor
    logic [31:0] rd_log [1100];
    logic [31:0] wa_log [1100];
    logic [31:0] wd_log [1100];
    logic [31:0] wb_log [1100];
    int nr, nw, nwb, ndone, nerr, ngrant, cur_burst, max_burst, side_bad, pause_viol;
    logic [31:0] exp_ctrl;

    // control from the stimulus tasks to the monitor
    bit          pend_load = 0, inject_load = 0, base_req = 0;
    bit          drop_at_wb = 0, drop_after_gnt = 0, gnt_rand = 0;
    int          hold_cnt = 0;
    logic [31:0] p_src, p_dst, p_ctrl;

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0000_5A3C;
    endfunction

    function automatic logic [31:0] mk(input int dinc, dsz, sinc, ssz, dpr, spr,
                                       arb, cnt, mode);
        logic [31:0] c = '0;
        c[31:30] = 2'(dinc); c[29:28] = 2'(dsz); c[27:26] = 2'(sinc); c[25:24] = 2'(ssz);
        c[21] = 1'(dpr); c[18] = 1'(spr); c[17:14] = 4'(arb); c[13:4] = 10'(cnt);
        c[2:0] = 3'(mode);
        return c;
    endfunction

    function automatic logic [31:0] exp_addr(input logic [31:0] e, input logic [1:0] st,
                                             input int n, input int k);
        logic [31:0] stepb = (st == 2'd3) ? 32'd0 : (32'd1 << st);
        return e - 32'(n - 1 - k) * stepb;
    endfunction

    function automatic int burst_len(input logic [3:0] a);
        return (a >= 4'd10) ? 1024 : (1 << a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // memory model, monitor, arbiter and all input driving
    always @(posedge clk) if (mem_rd) mem_rd_data <= mem_fn(mem_rd_addr);

    always @(negedge clk) begin
        if (mem_rd) begin
            if (nr < 1100) rd_log[nr] = mem_rd_addr;
            nr++;
        end
        if (mem_rd || mem_wr) begin
            if (mem_size != exp_ctrl[25:24] || mem_rd_priv != exp_ctrl[18] ||
                mem_wr_priv != exp_ctrl[21]) side_bad++;
        end
        if (mem_wr) begin
            if (nw < 1100) begin wa_log[nw] = mem_wr_addr; wd_log[nw] = mem_wr_data; end
            nw++;
            cur_burst++;
            if (cur_burst > max_burst) max_burst = cur_burst;
        end
        if (desc_wr) begin
            if (nwb < 1100) wb_log[nwb] = desc_ctrl;
            nwb++;
            if (drop_at_wb && !done) hold_cnt = 20;
        end
        if (done) ndone++;
        if (cfg_err) nerr++;
        if (hold_cnt > 0 && !desc_wr && (arb_req || mem_rd || mem_wr)) pause_viol++;
        // drive inputs
        load_valid = 1'b0;
        if (pend_load) begin
            load_valid = 1'b1; load_src_end = p_src; load_dst_end = p_dst; load_ctrl = p_ctrl;
            pend_load = 0;
        end else if (inject_load && nw == 2) begin
            load_valid = 1'b1; load_src_end = 32'hDEAD_0000; load_dst_end = 32'hBEEF_0000;
            load_ctrl = mk(0, 0, 0, 0, 1, 1, 0, 5, 1);
            inject_load = 0;
        end
        if (hold_cnt > 0 && !desc_wr) hold_cnt--;
        chan_req = base_req && (hold_cnt == 0);
        arb_gnt = 1'b0;
        if (arb_req && (!gnt_rand || ($urandom % 3 == 0))) begin
            arb_gnt = 1'b1;
            ngrant++;
            cur_burst = 0;
            if (drop_after_gnt) base_req = 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cycles, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic clear_logs(input logic [31:0] c);
        nr = 0; nw = 0; nwb = 0; ndone = 0; nerr = 0; ngrant = 0;
        cur_burst = 0; max_burst = 0; side_bad = 0; pause_viol = 0; exp_ctrl = c;
    endtask

    task automatic do_load(input logic [31:0] s, d, c);
        p_src = s; p_dst = d; p_ctrl = c; pend_load = 1;
        @(negedge clk);
    endtask

    // full run of a legal descriptor, compared with values from the requirements
    task automatic run(input logic [31:0] s, d, c, input bit basic_drop,
                       input bit auto_drop, input bit inject);
        int n = int'(c[13:4]) + 1;
        int b = burst_len(c[17:14]);
        int nb = (n + b - 1) / b;
        int t = 0;
        int bad_ra = 0, bad_wa = 0, bad_wd = 0, bad_wb = 0;
        logic [31:0] wexp;
        clear_logs(c);
        base_req = 1; drop_at_wb = basic_drop; drop_after_gnt = auto_drop;
        inject_load = inject;
        do_load(s, d, c);
        while (ndone == 0 && t < 40000) begin @(negedge clk); t++; end
        @(negedge clk);
        drop_at_wb = 0; drop_after_gnt = 0; inject_load = 0; hold_cnt = 0;
        chk(nr == n && nw == n, "R5", "item count", 32'(nw), 32'(n));
        for (int k = 0; k < n && k < nr; k++)
            if (rd_log[k] != exp_addr(s, c[27:26], n, k)) bad_ra++;
        chk(bad_ra == 0, "R4", "source address mismatches", 32'(bad_ra), 0);
        for (int k = 0; k < n && k < nw; k++) begin
            if (wa_log[k] != exp_addr(d, c[31:30], n, k)) bad_wa++;
            if (k < nr && wd_log[k] != mem_fn(rd_log[k])) bad_wd++;
        end
        chk(bad_wa == 0, "R4", "destination address mismatches", 32'(bad_wa), 0);
        chk(bad_wd == 0, "R5", "write data mismatches", 32'(bad_wd), 0);
        chk(max_burst <= b, "R6", "items per grant", 32'(max_burst), 32'(b));
        chk(ngrant == nb, "R6", "grant count", 32'(ngrant), 32'(nb));
        chk(nwb == nb, "R7", "write-back count", 32'(nwb), 32'(nb));
        for (int j = 0; j + 1 < nb && j < nwb; j++) begin
            wexp = c; wexp[13:4] = 10'(n - (j + 1) * b - 1);
            if (wb_log[j] != wexp) bad_wb++;
        end
        chk(bad_wb == 0, "R7", "intermediate write-back mismatches", 32'(bad_wb), 0);
        wexp = c; wexp[13:4] = '0; wexp[2:0] = '0;
        chk(nwb > 0 && wb_log[(nwb > 0) ? nwb - 1 : 0] == wexp, "R8", "final control word",
            wb_log[(nwb > 0) ? nwb - 1 : 0], wexp);
        chk(ndone == 1, "R8", "done pulses", 32'(ndone), 1);
        chk(side_bad == 0, "R11", "size/privilege mismatches", 32'(side_bad), 0);
        if (basic_drop)
            chk(pause_viol == 0, "R9", "activity during paused request", 32'(pause_viol), 0);
        if (auto_drop)
            chk(ndone == 1 && chan_req == 1'b0, "R10", "completion without request",
                32'(ndone), 1);
        if (inject)
            chk(rd_log[0] == exp_addr(s, c[27:26], n, 0), "R12", "first read after busy load",
                rd_log[0], exp_addr(s, c[27:26], n, 0));
    endtask

    // a descriptor that must move nothing
    task automatic probe(input logic [31:0] c, input int exp_err, input string req);
        clear_logs(c);
        base_req = 1;
        do_load(32'h100, 32'h200, c);
        repeat (30) @(negedge clk);
        chk(nr == 0 && nw == 0, req, "memory accesses", 32'(nr + nw), 0);
        chk(ndone == 0 && ngrant == 0, req, "done or grant", 32'(ndone + ngrant), 0);
        chk(nerr == exp_err, req, "cfg_err pulses", 32'(nerr), 32'(exp_err));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!arb_req && !mem_rd && !mem_wr && !desc_wr && !done && !cfg_err && !busy,
            "R1", "outputs in reset", {25'd0, arb_req, mem_rd, mem_wr, desc_wr, done, cfg_err, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !arb_req, "R1", "idle after reset", 32'(busy), 0);

        // R2 stop mode
        probe(mk(2, 2, 2, 2, 0, 0, 2, 7, 0), 0, "R2");
        // R3 illegal configurations
        probe(mk(0, 3, 0, 3, 0, 0, 2, 7, 1), 1, "R3");   // reserved size
        probe(mk(2, 1, 2, 2, 0, 0, 2, 7, 1), 1, "R3");   // sizes differ
        probe(mk(2, 2, 1, 2, 0, 0, 2, 7, 2), 1, "R3");   // source step too small
        probe(mk(0, 1, 3, 1, 0, 0, 2, 7, 1), 1, "R3");   // destination step too small
        probe(mk(2, 2, 2, 2, 0, 0, 2, 7, 5), 1, "R3");   // unsupported mode

        // directed corners
        run(32'h0000_1000, 32'h0000_8000, mk(2, 2, 2, 2, 1, 0, 0, 0, 1), 0, 0, 0); // N = 1
        run(32'h4000_0010, 32'h2000_0000, mk(3, 0, 3, 0, 0, 1, 1, 6, 2), 0, 0, 0); // fixed pointers
        run(32'h0001_0000, 32'h0003_0000, mk(2, 2, 2, 2, 1, 1, 12, 1023, 1), 0, 0, 0); // no re-arb
        run(32'h0005_0000, 32'h0007_0000, mk(0, 0, 1, 0, 0, 0, 9, 1023, 2), 0, 0, 0); // two bursts
        run(32'h0000_3000, 32'h0000_5000, mk(1, 1, 1, 1, 0, 1, 1, 9, 1), 1, 0, 0);   // R9 pause
        run(32'h0000_7000, 32'h0000_9000, mk(2, 1, 3, 1, 1, 0, 2, 13, 2), 0, 1, 0);  // R10
        run(32'h0000_A000, 32'h0000_C000, mk(0, 0, 0, 0, 0, 0, 3, 11, 1), 0, 0, 1);  // R12

        // constrained random
        gnt_rand = 1;
        for (int i = 0; i < 24; i++) begin
            int sz = int'($urandom % 3);
            int si = sz + int'($urandom % (4 - sz));
            int di = sz + int'($urandom % (4 - sz));
            int md = 1 + int'($urandom % 2);
            run($urandom, $urandom, mk(di, sz, si, sz, int'($urandom % 2), int'($urandom % 2),
                int'($urandom % 6), int'($urandom % 40), md),
                (md == 1) && ($urandom % 2 == 1), (md == 2) && ($urandom % 2 == 1), 0);
        end
        gnt_rand = 0;
        probe(mk(2, 2, 2, 2, 0, 0, 2, 7, 0), 0, "R2");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule